// File: doc/BRIEF.md
# Configurable Serial Audio Slot Receiver

This block takes a serial audio stream on a bit clock, a frame-sync line and one data line, and returns one pair of 20-bit samples per audio frame. It runs entirely on the incoming bit clock. A two-bit format input selects how frames are built: a plain two-channel stereo frame of 64 bits, a four-slot multiplexed frame of 128 bits, or an eight-slot multiplexed frame of 256 bits. A two-bit pair input picks which adjacent slot pair is taken from an eight-slot frame.

Every slot is 32 bits wide and arrives most significant bit first. Only the leading 20 bits of a slot are kept. When the second slot of the chosen pair has delivered its twentieth bit, both words are published together and a one-cycle valid strobe marks them. The block watches the sync line and flags frames whose length does not fit the selected format. In multiplexed formats it also flags a sync pulse that stays high too long. The format and pair inputs are expected to be changed only while the block is held in reset.

Top module: `i2s_tdm_rx`

## Requirements
- R1: After reset, `left_word` and `right_word` are zero, and `out_valid` and `frame_err` are low.
- R2: Each slot is 32 bits, sampled on the rising edge of `bclk`, MSB first. A published word is the first 20 bits of its slot, with the first bit received as bit 19. The remaining 12 bits of the slot do not affect any output.
- R3: With `cfg_fmt` = 00 (stereo), a frame starts at a high-to-low change of `fsync`, and its MSB comes one bit later. The left word is slot 0, which is sent while `fsync` is low. The right word is slot 1, whose MSB comes one bit after `fsync` rises. The frame is 64 bits long.
- R4: With `cfg_fmt` = 01 or 10 (four slots, 128-bit frame), a frame starts at a low-to-high change of `fsync`, and the MSB of slot 0 comes one bit later. Code 01 extracts slots 0 and 1. Code 10 extracts slots 2 and 3.
- R5: With `cfg_fmt` = 11 (eight slots, 256-bit frame, same sync rule as R4), `cfg_pair` = p extracts slots 2p (left) and 2p+1 (right).
- R6: `out_valid` is high for exactly one cycle: the cycle after the rising edge that samples bit 19 of the right slot. `left_word` and `right_word` change only in that cycle.
- R7: When a sync edge arrives and the number of bits since the previous sync edge differs from 64, 128 or 256 (as the format selects), `frame_err` is high for one cycle, the cycle after that edge. The first sync edge after reset is not judged.
- R8: In the four-slot formats, an `fsync` pulse sampled high on more than 127 consecutive edges raises `frame_err` for one cycle, the cycle after the 128th high sample. In the eight-slot format the limit is 255 samples. In stereo format a long high level raises no error.
- R9: No word is published before the first frame start after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Serial bit clock; all logic runs on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame sync line |
| sdata | input | 1 | Serial data line |
| cfg_fmt | input | 2 | Frame format: 00 stereo, 01/10 four-slot, 11 eight-slot |
| cfg_pair | input | 2 | Slot pair selected in the eight-slot format |
| left_word | output | 20 | Published sample from the first slot of the pair |
| right_word | output | 20 | Published sample from the second slot of the pair |
| out_valid | output | 1 | One-cycle strobe for a new word pair |
| frame_err | output | 1 | One-cycle flag for a bad frame length or an over-long sync pulse |

## Verification
Publishing a word pair and flagging a frame error can happen on the same edge. This occurs when a short frame ends with its sync edge exactly on the bit that completes the right word. The bench uses the four-slot format with code 10 and a 116-bit frame, so the sync edge lands on bit 19 of slot 3. It then requires that the strobe and the error flag are seen in the same cycle, and that the published right word still holds the full 20 bits of slot 3.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;

  typedef enum logic [1:0] {
    FMT_STEREO = 2'b00,
    FMT_QUAD_A = 2'b01,
    FMT_QUAD_B = 2'b10,
    FMT_OCTO   = 2'b11
  } fmt_e;

  // number of 32-bit slots in one frame
  function automatic int unsigned slots_per_frame(input logic [1:0] fmt);
    case (fmt)
      FMT_STEREO:             return 2;
      FMT_QUAD_A, FMT_QUAD_B: return 4;
      default:                return 8;
    endcase
  endfunction

  // index of the left slot of the extracted pair
  function automatic int unsigned first_slot(input logic [1:0] fmt, input logic [1:0] pair);
    case (fmt)
      FMT_QUAD_B: return 2;
      FMT_OCTO:   return 2 * int'(pair);
      default:    return 0;
    endcase
  endfunction

  // longest legal run of high sync samples (multiplexed formats only)
  function automatic int unsigned sync_high_max(input logic [1:0] fmt);
    case (fmt)
      FMT_QUAD_A, FMT_QUAD_B: return 127;
      FMT_OCTO:               return 255;
      default:                return 0;
    endcase
  endfunction

endpackage

// File: rtl/tdm_sync_tracker.sv
module tdm_sync_tracker
  import tdm_rx_pkg::*;
#(
  parameter int SLOT_BITS = 32,
  parameter int CNT_W     = 9
) (
  input  logic             bclk,
  input  logic             rst_n,
  input  logic             fsync,
  input  logic [1:0]       fmt,
  output logic             sync_edge,
  output logic [CNT_W-1:0] bit_idx,
  output logic             locked,
  output logic             frame_err
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             fsync_q;
  logic [CNT_W-1:0] hi_cnt;
  logic [CNT_W-1:0] last_idx;
  logic [CNT_W-1:0] hi_limit;
  logic             is_stereo;
  logic             len_bad;
  logic             hi_bad;

  assign is_stereo = (fmt == FMT_STEREO);
  assign last_idx  = CNT_W'(slots_per_frame(fmt) * SLOT_BITS - 1);
  assign hi_limit  = CNT_W'(sync_high_max(fmt));

  // stereo frames begin on a falling sync, multiplexed frames on a rising one
  assign sync_edge = is_stereo ? (fsync_q & ~fsync) : (~fsync_q & fsync);
  assign len_bad   = sync_edge && locked && (bit_idx != last_idx);
  assign hi_bad    = !is_stereo && fsync && (hi_cnt == hi_limit);

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      fsync_q   <= 1'b0;
      bit_idx   <= CNT_MAX;
      hi_cnt    <= '0;
      locked    <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      fsync_q   <= fsync;
      frame_err <= len_bad | hi_bad;
      if (sync_edge) begin
        bit_idx <= '0;
        locked  <= 1'b1;
      end else if (bit_idx != CNT_MAX) begin
        bit_idx <= bit_idx + 1'b1;
      end
      if (!fsync)                hi_cnt <= '0;
      else if (hi_cnt != CNT_MAX) hi_cnt <= hi_cnt + 1'b1;
    end
  end

  // frame start realigns the bit counter (R3, R4)
  assert_idx_realign_R4: assert property (@(posedge bclk) disable iff (!rst_n)
    sync_edge |=> (bit_idx == '0));

  // wrong frame length is reported one cycle after the edge (R7)
  assert_len_flag_R7: assert property (@(posedge bclk) disable iff (!rst_n)
    (sync_edge && locked && (bit_idx != last_idx)) |=> frame_err);

  // over-long multiplexed sync pulse is reported (R8)
  assert_sync_width_R8: assert property (@(posedge bclk) disable iff (!rst_n)
    (!is_stereo && fsync && (hi_cnt == hi_limit)) |=> frame_err);

  // no error on a stereo frame that has exactly the right length (R7)
  assert_no_false_err_R7: assert property (@(posedge bclk) disable iff (!rst_n)
    (is_stereo && !sync_edge) |=> !frame_err);

endmodule

// File: rtl/tdm_slot_capture.sv
module tdm_slot_capture
  import tdm_rx_pkg::*;
#(
  parameter int SLOT_BITS = 32,
  parameter int KEEP_BITS = 20,
  parameter int CNT_W     = 9
) (
  input  logic                 bclk,
  input  logic                 rst_n,
  input  logic                 sdata,
  input  logic [CNT_W-1:0]     bit_idx,
  input  logic                 locked,
  input  logic [1:0]           fmt,
  input  logic [1:0]           pair,
  output logic [KEEP_BITS-1:0] left_word,
  output logic [KEEP_BITS-1:0] right_word,
  output logic                 out_valid
);

  localparam int POS_W  = $clog2(SLOT_BITS);
  localparam int SLOT_W = CNT_W - POS_W;

  logic [SLOT_W-1:0]    slot_no;
  logic [POS_W-1:0]     pos;
  logic [SLOT_W-1:0]    slot_a;
  logic [SLOT_W-1:0]    slot_b;
  logic                 in_keep;
  logic                 keep_a, keep_b;
  logic                 last_a, last_b;
  logic [KEEP_BITS-1:0] shreg;
  logic [KEEP_BITS-1:0] pend_left;
  logic [KEEP_BITS-1:0] next_word;

  assign slot_no   = bit_idx[CNT_W-1:POS_W];
  assign pos       = bit_idx[POS_W-1:0];
  assign slot_a    = SLOT_W'(first_slot(fmt, pair));
  assign slot_b    = slot_a + 1'b1;
  assign in_keep   = locked && (int'(pos) < KEEP_BITS);
  assign keep_a    = in_keep && (slot_no == slot_a);
  assign keep_b    = in_keep && (slot_no == slot_b);
  assign last_a    = keep_a && (int'(pos) == KEEP_BITS - 1);
  assign last_b    = keep_b && (int'(pos) == KEEP_BITS - 1);
  assign next_word = {shreg[KEEP_BITS-2:0], sdata};

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      shreg      <= '0;
      pend_left  <= '0;
      left_word  <= '0;
      right_word <= '0;
      out_valid  <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (keep_a || keep_b) shreg <= next_word;
      if (last_a) pend_left <= next_word;
      if (last_b) begin
        left_word  <= pend_left;
        right_word <= next_word;
        out_valid  <= 1'b1;
      end
    end
  end

  // strobe lasts a single cycle (R6)
  assert_valid_single_R6: assert property (@(posedge bclk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // published words move only together with the strobe (R6)
  assert_words_hold_R6: assert property (@(posedge bclk) disable iff (!rst_n)
    (!$stable(right_word) || !$stable(left_word)) |-> out_valid);

  // nothing is published before frame alignment (R9)
  assert_no_early_word_R9: assert property (@(posedge bclk) disable iff (!rst_n)
    !locked |=> !out_valid);

endmodule

// File: rtl/i2s_tdm_rx.sv
module i2s_tdm_rx #(
  parameter int SLOT_BITS = 32,
  parameter int KEEP_BITS = 20
) (
  input  logic                 bclk,
  input  logic                 rst_n,
  input  logic                 fsync,
  input  logic                 sdata,
  input  logic [1:0]           cfg_fmt,
  input  logic [1:0]           cfg_pair,
  output logic [KEEP_BITS-1:0] left_word,
  output logic [KEEP_BITS-1:0] right_word,
  output logic                 out_valid,
  output logic                 frame_err
);

  localparam int MAX_SLOTS = 8;
  localparam int CNT_W     = $clog2(MAX_SLOTS * SLOT_BITS) + 1;

  logic             sync_edge;
  logic [CNT_W-1:0] bit_idx;
  logic             locked;

  tdm_sync_tracker #(
    .SLOT_BITS (SLOT_BITS),
    .CNT_W     (CNT_W)
  ) u_tracker (
    .bclk      (bclk),
    .rst_n     (rst_n),
    .fsync     (fsync),
    .fmt       (cfg_fmt),
    .sync_edge (sync_edge),
    .bit_idx   (bit_idx),
    .locked    (locked),
    .frame_err (frame_err)
  );

  tdm_slot_capture #(
    .SLOT_BITS (SLOT_BITS),
    .KEEP_BITS (KEEP_BITS),
    .CNT_W     (CNT_W)
  ) u_capture (
    .bclk       (bclk),
    .rst_n      (rst_n),
    .sdata      (sdata),
    .bit_idx    (bit_idx),
    .locked     (locked),
    .fmt        (cfg_fmt),
    .pair       (cfg_pair),
    .left_word  (left_word),
    .right_word (right_word),
    .out_valid  (out_valid)
  );

  // a frame start in the same cycle as a publish must not drop the strobe (R6, R7)
  assert_publish_at_edge_R6: assert property (@(posedge bclk) disable iff (!rst_n)
    (sync_edge && locked && (bit_idx[4:0] == 5'(KEEP_BITS - 1)) && (cfg_fmt == 2'b10)
     && (bit_idx[CNT_W-1:5] == 3)) |=> out_valid);

endmodule

// File: tb/i2s_tdm_rx_bench.sv
module i2s_tdm_rx_bench;

  logic        bclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fsync = 1'b0;
  logic        sdata = 1'b0;
  logic [1:0]  cfg_fmt = 2'b00;
  logic [1:0]  cfg_pair = 2'b00;
  logic [19:0] left_word, right_word;
  logic        out_valid, frame_err;

  i2s_tdm_rx u_i2s_tdm_rx (
    .bclk(bclk), .rst_n(rst_n), .fsync(fsync), .sdata(sdata),
    .cfg_fmt(cfg_fmt), .cfg_pair(cfg_pair),
    .left_word(left_word), .right_word(right_word),
    .out_valid(out_valid), .frame_err(frame_err)
  );

  always #10 bclk = ~bclk;

  int n_chk = 0, n_fail = 0;
  int call_no = 0;
  int v_seen = 0, v_call = -1, e_seen = 0, e_call = -1;
  logic [19:0] v_l, v_r;
  logic [31:0] slot_data [8];
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic drive_bit(input logic w, input logic d);
    @(negedge bclk);
    if (out_valid) begin v_seen++; v_call = call_no; v_l = left_word; v_r = right_word; end
    if (frame_err) begin e_seen++; e_call = call_no; end
    fsync = w; sdata = d; call_no++;
  endtask

  task automatic do_reset(input logic [1:0] fmt, input logic [1:0] pair);
    rst_n = 1'b0; fsync = 1'b0; sdata = 1'b0; cfg_fmt = fmt; cfg_pair = pair;
    repeat (3) @(negedge bclk);
    rst_n = 1'b1;
    call_no = 0; v_seen = 0; v_call = -1; e_seen = 0; e_call = -1;
  endtask

  task automatic fill(input int seed);
    for (int k = 0; k < 8; k++) slot_data[k] = 32'h9E37_79B9 * (seed * 8 + k + 1) ^ (32'h5A5 << k);
  endtask

  task automatic preamble(input bit tdm);
    if (tdm) begin drive_bit(1'b0, 1'b0); drive_bit(1'b1, 1'b0); end
    else     begin drive_bit(1'b1, 1'b0); drive_bit(1'b0, 1'b0); end
  endtask

  task automatic drive_frame(input int len, input bit tdm, input int hi, output int f0);
    f0 = call_no;
    for (int i = 0; i < len; i++) begin
      logic w, d;
      d = (i / 32 < 8) ? slot_data[i / 32][31 - (i % 32)] : 1'b0;
      if (tdm) w = (i < hi - 1) || (i == len - 1);
      else     w = (i >= len / 2 - 1) && (i <= len - 2);
      drive_bit(w, d);
    end
  endtask

  // two good frames in one format; checks pair selection, 20-bit trim, strobe timing
  task automatic run_frames(input logic [1:0] fmt, input logic [1:0] pair, input int len,
                            input bit tdm, input int hi, input int sa, input string req);
    int f0;
    do_reset(fmt, pair);
    preamble(tdm);
    for (int fr = 0; fr < 2; fr++) begin
      fill(fr + sa * 3 + int'(fmt) * 11);
      v_seen = 0;
      drive_frame(len, tdm, hi, f0);
      chk(v_seen == 1, req, "R6 strobe count", v_seen, 1);
      chk(v_call == f0 + (sa + 1) * 32 + 20, "R6", "strobe cycle", v_call, f0 + (sa + 1) * 32 + 20);
      chk(v_l == slot_data[sa][31:12], req, "R2 left word", v_l, slot_data[sa][31:12]);
      chk(v_r == slot_data[sa + 1][31:12], req, "R2 right word", v_r, slot_data[sa + 1][31:12]);
    end
    drive_bit(tdm ? 1'b0 : 1'b0, 1'b0);
    chk(e_seen == 0, "R7", "no error on good frames", e_seen, 0);
  endtask

  task automatic test_reset;
    do_reset(2'b00, 2'b00);
    @(negedge bclk);
    chk(left_word == 0 && right_word == 0, "R1", "words after reset", {left_word, right_word}, 0);
    chk(out_valid == 0 && frame_err == 0, "R1", "flags after reset", {out_valid, frame_err}, 0);
  endtask

  task automatic test_unlocked;
    do_reset(2'b01, 2'b00);
    for (int i = 0; i < 300; i++) drive_bit(1'b0, 1'((i * 7) % 3 == 0));
    chk(v_seen == 0, "R9", "no strobe before frame start", v_seen, 0);
    chk(right_word == 0, "R9", "word untouched", right_word, 0);
  endtask

  task automatic test_length;
    int f0, f1, f2;
    do_reset(2'b01, 2'b00);
    fill(40);
    preamble(1'b1);
    drive_frame(120, 1'b1, 1, f0);
    drive_frame(128, 1'b1, 1, f1);
    chk(e_seen == 1, "R7", "short frame flagged", e_seen, 1);
    chk(e_call == f0 + 120, "R7", "short flag cycle", e_call, f0 + 120);
    drive_frame(136, 1'b1, 1, f2);
    drive_bit(1'b0, 1'b0);
    chk(e_seen == 2, "R7", "long frame flagged", e_seen, 2);
  endtask

  task automatic test_coincide;
    int f0, f1;
    do_reset(2'b10, 2'b00);
    fill(77);
    preamble(1'b1);
    drive_frame(116, 1'b1, 1, f0);
    drive_frame(128, 1'b1, 1, f1);
    drive_bit(1'b0, 1'b0);
    chk(e_call == f0 + 116, "R7", "error at coincident edge", e_call, f0 + 116);
    chk(v_seen >= 1 && v_call > f0 + 116, "R6", "later strobe from next frame", v_call, f0 + 116 + 116);
  endtask

  task automatic test_coincide_same;
    int f0;
    do_reset(2'b10, 2'b00);
    fill(78);
    preamble(1'b1);
    drive_frame(116, 1'b1, 1, f0);
    drive_bit(1'b0, 1'b0);
    chk(v_call == f0 + 116 && e_call == f0 + 116, "R6", "strobe and error same cycle", v_call, e_call);
    chk(v_r == slot_data[3][31:12], "R4", "right word at coincident edge", v_r, slot_data[3][31:12]);
  endtask

  task automatic hi_run(input logic [1:0] fmt, input int n_high, input int exp_err);
    do_reset(fmt, 2'b00);
    drive_bit(1'b0, 1'b0);
    repeat (n_high) drive_bit(1'b1, 1'b0);
    repeat (3) drive_bit(1'b0, 1'b0);
    chk(e_seen == exp_err, "R8", $sformatf("sync high %0d fmt %0d", n_high, fmt), e_seen, exp_err);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    test_reset();
    test_unlocked();
    run_frames(2'b00, 2'b00, 64, 1'b0, 1, 0, "R3");
    run_frames(2'b01, 2'b00, 128, 1'b1, 100, 0, "R4");
    run_frames(2'b10, 2'b00, 128, 1'b1, 1, 2, "R4");
    for (int p = 0; p < 4; p++)
      run_frames(2'b11, 2'(p), 256, 1'b1, (p == 1) ? 200 : 1, 2 * p, "R5");
    test_length();
    test_coincide();
    test_coincide_same();
    hi_run(2'b01, 127, 0);
    hi_run(2'b01, 128, 1);
    hi_run(2'b11, 255, 0);
    hi_run(2'b11, 256, 1);
    hi_run(2'b00, 300, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule